// File: doc/BRIEF.md
# Asynchronous External Memory Access Sequencer

This block runs single asynchronous read and write accesses to an external static memory, counted in system clock cycles. Each access has up to three phases. An address setup phase comes first. An address hold phase follows, but only when the address and data share the same lines. A data phase comes last. A 16-bit timing word sets the length of each phase. The block loads this word from a write port, and it applies limits to each field: a zero length where zero is not allowed becomes one, and a phase that the bus mode requires always lasts at least one cycle.

The host pulses `req` while the block is idle, together with the direction, the address, the write data and the bus mode. The block then drives chip select, address-valid, output enable, write enable and the address and data lines. When the access ends it pulses `ack` for one cycle, and on a read it also presents the captured data. At the start of each access the block takes a snapshot of the timing word and the mode, so a write to the timing word changes only the accesses that start after it.

Top module: `amem_seq`

## Requirements
- R1: `cfg_wdata` is loaded into the timing word on a clock edge where `cfg_we` is high. Bits 15:8 set the data length D, bits 7:4 set the hold length H and bits 3:0 set the setup length S.
- R2: After reset the timing word is 0xFFFF. A non-multiplexed access therefore has 15 setup cycles and 255 data cycles.
- R3: The data phase lasts D cycles, with D from 1 to 255. During it `mem_oe_n` is low on a read and `mem_we_n` is low on a write. The two strobes are never low at the same time.
- R4: A D field of 0 gives a data phase of 1 cycle.
- R5: In non-multiplexed mode the setup phase lasts S cycles. When S is 0 the data phase starts in the first access cycle.
- R6: In multiplexed mode (`req_mux`=1) the setup phase lasts max(S,1) cycles.
- R7: A hold phase of H cycles (H=0 gives 1) comes between setup and data, but only in multiplexed mode. Non-multiplexed accesses have no hold cycles.
- R8: `mem_adv_n` is low exactly during the setup cycles of a multiplexed access. During the setup and hold cycles of that access, `mem_dq_oe`=1 and `mem_dq_out` carries the address.
- R9: `mem_cs_n` goes low in the cycle right after `req` is sampled. It stays low without a break up to the last data cycle, and it is high otherwise. `mem_addr` holds the address while `mem_cs_n` is low.
- R10: On a read, `rd_data` shows the `mem_dq_in` value sampled at the end of the last data cycle. It holds that value until the next read completes.
- R11: `ack` is high for exactly one cycle, the cycle after the last data cycle, and all strobes are high in that cycle. `req` is ignored unless the block is idle.
- R12: The timing word and the mode are sampled when an access starts. A write to the timing word during an access applies only to later accesses.
- R13: On a write, `mem_dq_out` carries the write data with `mem_dq_oe`=1 throughout the data phase. On a read, `mem_dq_oe` is 0 during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 16 | New timing word |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mux | input | 1 | 1 = multiplexed address/data access |
| req_addr | input | AW (16) | Access address |
| req_wdata | input | DW (16) | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | DW (16) | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW (16) | Address lines |
| mem_dq_out | output | DW (16) | Data lines, outbound value |
| mem_dq_oe | output | 1 | Data line drive enable |
| mem_dq_in | input | DW (16) | Data lines, inbound value |

## Verification
A request driven at one falling edge is accepted at the next rising edge, so chip select must be low at the falling edge right after that. From then on, each cycle of the access is classified at a falling edge: setup or hold while no strobe is low, data while a strobe is low. The bench checks the number of cycles of each kind against the effective lengths it computed for that access. `ack` and `rd_data` are due at the first falling edge where chip select is high again, and `ack` must be low one cycle later. The expected read value is the inbound data present at the falling edge of the last strobe cycle, which is the value the design captures at the rising edge that ends that cycle.

// File: rtl/amem_pkg.sv
package amem_pkg;
  localparam int SET_W = 4;
  localparam int HLD_W = 4;
  localparam int DAT_W = 8;
  localparam int CFG_W = SET_W + HLD_W + DAT_W;
  localparam int CNT_W = DAT_W;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_HOLD, PH_DATA, PH_DONE} amem_phase_e;

  function automatic logic [SET_W-1:0] eff_setup(input logic [SET_W-1:0] f, input logic mux);
    return (mux && f == '0) ? SET_W'(1) : f;
  endfunction

  function automatic logic [HLD_W-1:0] eff_hold(input logic [HLD_W-1:0] f);
    return (f == '0) ? HLD_W'(1) : f;
  endfunction

  function automatic logic [DAT_W-1:0] eff_data(input logic [DAT_W-1:0] f);
    return (f == '0) ? DAT_W'(1) : f;
  endfunction
endpackage

// File: rtl/amem_timing_reg.sv
module amem_timing_reg
  import amem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mux_in,
  output logic [SET_W-1:0] set_len,
  output logic [HLD_W-1:0] hld_len,
  output logic [DAT_W-1:0] dat_len
);
  localparam int HLD_LO = SET_W;
  localparam int DAT_LO = SET_W + HLD_W;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '1;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_comb begin
    set_len = eff_setup(cfg_q[SET_W-1:0], mux_in);
    hld_len = eff_hold(cfg_q[HLD_LO +: HLD_W]);
    dat_len = eff_data(cfg_q[DAT_LO +: DAT_W]);
  end

  // R1: a write lands in the word on the following cycle
  p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata));
  // R4: the data length handed on is never zero
  p_dat_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_len != '0);
endmodule

// File: rtl/amem_phase_fsm.sv
module amem_phase_fsm
  import amem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mux_in,
  input  logic             write_in,
  input  logic [SET_W-1:0] set_len,
  input  logic [HLD_W-1:0] hld_len,
  input  logic [DAT_W-1:0] dat_len,
  output amem_phase_e      phase,
  output logic             mux_q,
  output logic             wr_q,
  output logic             last_data
);
  amem_phase_e      nxt;
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic [HLD_W-1:0] hld_q;
  logic [DAT_W-1:0] dat_q;
  logic             phase_end;

  assign phase_end = (cnt == CNT_W'(1));
  assign last_data = (phase == PH_DATA) && phase_end;

  always_comb begin
    nxt     = phase;
    nxt_cnt = cnt;
    case (phase)
      PH_IDLE: if (start) begin
        if (set_len != '0) begin
          nxt = PH_SETUP; nxt_cnt = CNT_W'(set_len);
        end else if (mux_in) begin
          nxt = PH_HOLD;  nxt_cnt = CNT_W'(hld_len);
        end else begin
          nxt = PH_DATA;  nxt_cnt = CNT_W'(dat_len);
        end
      end
      PH_SETUP: if (phase_end) begin
        if (mux_q) begin nxt = PH_HOLD; nxt_cnt = CNT_W'(hld_q); end
        else       begin nxt = PH_DATA; nxt_cnt = CNT_W'(dat_q); end
      end else nxt_cnt = cnt - 1'b1;
      PH_HOLD: if (phase_end) begin
        nxt = PH_DATA; nxt_cnt = CNT_W'(dat_q);
      end else nxt_cnt = cnt - 1'b1;
      PH_DATA: if (phase_end) begin
        nxt = PH_DONE; nxt_cnt = '0;
      end else nxt_cnt = cnt - 1'b1;
      default: begin nxt = PH_IDLE; nxt_cnt = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      hld_q <= '0;
      dat_q <= '0;
      mux_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      phase <= nxt;
      cnt   <= nxt_cnt;
      if (phase == PH_IDLE && start) begin
        hld_q <= hld_len;
        dat_q <= dat_len;
        mux_q <= mux_in;
        wr_q  <= write_in;
      end
    end
  end

  // R11: the completion cycle is always followed by idle
  p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DONE |=> phase == PH_IDLE);
  // R7: a hold cycle only occurs in a multiplexed access
  p_hold_mux_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_HOLD |-> mux_q);
  // R6: a multiplexed start always enters setup
  p_mux_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start && mux_in) |=> phase == PH_SETUP);
  // R3: a timed phase never runs with an empty count
  p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP || phase == PH_HOLD || phase == PH_DATA) |-> cnt != '0);
endmodule

// File: rtl/amem_pin_drv.sv
module amem_pin_drv
  import amem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  amem_phase_e    phase,
  input  logic           mux_q,
  input  logic           wr_q,
  input  logic [AW-1:0]  addr_q,
  input  logic [DW-1:0]  wdata_q,
  output logic           cs_n,
  output logic           adv_n,
  output logic           oe_n,
  output logic           we_n,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  dq_o,
  output logic           dq_oe
);
  logic active, addr_on_dq;

  always_comb begin
    active     = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);
    addr_on_dq = mux_q && ((phase == PH_SETUP) || (phase == PH_HOLD));
    cs_n       = !active;
    adv_n      = !(mux_q && phase == PH_SETUP);
    oe_n       = !(phase == PH_DATA && !wr_q);
    we_n       = !(phase == PH_DATA && wr_q);
    addr_o     = addr_q;
    dq_o       = addr_on_dq ? addr_q[DW-1:0] : wdata_q;
    dq_oe      = addr_on_dq || (wr_q && phase == PH_DATA);
  end
endmodule

// File: rtl/amem_seq.sv
module amem_seq
  import amem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req,
  input  logic             req_write,
  input  logic             req_mux,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             ack,
  output logic [DW-1:0]    rd_data,
  output logic             mem_cs_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  amem_phase_e      phase;
  logic             start, mux_q, wr_q, last_data, rd_capture;
  logic [SET_W-1:0] set_len;
  logic [HLD_W-1:0] hld_len;
  logic [DAT_W-1:0] dat_len;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rd_q;

  assign start      = req && (phase == PH_IDLE);
  assign rd_capture = last_data && !wr_q;
  assign ack        = (phase == PH_DONE);
  assign rd_data    = rd_q;

  amem_timing_reg u_treg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mux_in(req_mux), .set_len(set_len), .hld_len(hld_len), .dat_len(dat_len)
  );

  amem_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mux_in(req_mux), .write_in(req_write),
    .set_len(set_len), .hld_len(hld_len), .dat_len(dat_len),
    .phase(phase), .mux_q(mux_q), .wr_q(wr_q), .last_data(last_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rd_q <= mem_dq_in;
    end
  end

  amem_pin_drv #(.AW(AW), .DW(DW)) u_pins (
    .phase(phase), .mux_q(mux_q), .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .cs_n(mem_cs_n), .adv_n(mem_adv_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .addr_o(mem_addr), .dq_o(mem_dq_out), .dq_oe(mem_dq_oe)
  );

  // R3: read and write strobes are exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  // R11: the completion pulse lasts one cycle with chip select released
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> mem_cs_n ##1 !ack);
  // R8: address-valid only inside a selected cycle with the lines driven
  p_adv_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_cs_n && mem_dq_oe));
  // R10: read data only moves at the end of a read data phase
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rd_data));
endmodule

// File: tb/tb_amem_seq.sv
`timescale 1ns/1ps
module tb_amem_seq;
  localparam int AW = 16;
  localparam int DW = 16;

  typedef struct {
    int         pre;
    int         adv;
    int         dat;
    bit         wr;
    bit         mux;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic req = 0, req_write = 0, req_mux = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out;
  logic [DW-1:0] mem_dq_in = 16'h0000;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, cycles = 0;
  exp_t q[$];
  logic [15:0] cur_cfg = 16'hFFFF;
  bit finished = 0;

  always #2 clk = ~clk;

  amem_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .req_write(req_write), .req_mux(req_mux), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always @(posedge clk) begin
    #1 mem_dq_in <= mem_dq_in + 16'h1357;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, act, act, exp, exp);
    end
  endtask

  // ---- monitor ----
  bit in_acc = 0, ack_drop = 0;
  int m_pre, m_adv, m_dat, m_badaddr, m_baddq, m_oe, m_we;
  logic [DW-1:0] m_last;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_drop) begin
        chk(ack == 1'b0, "R11 ack width", ack, 0);
        ack_drop = 0;
      end
      if (!mem_cs_n) begin
        if (!in_acc) begin
          in_acc = 1;
          m_pre = 0; m_adv = 0; m_dat = 0; m_badaddr = 0; m_baddq = 0; m_oe = 0; m_we = 0;
          chk(q.size() > 0, "R11 access without accepted req", q.size(), 1);
          if (q.size() > 0) cur = q.pop_front();
        end
        if (mem_addr !== cur.addr) m_badaddr++;
        if (mem_oe_n && mem_we_n) begin
          m_pre++;
          if (!mem_adv_n) m_adv++;
          if (cur.mux && (!mem_dq_oe || mem_dq_out !== cur.addr[DW-1:0])) m_baddq++;
        end else begin
          m_dat++;
          if (!mem_oe_n) m_oe++;
          if (!mem_we_n) m_we++;
          m_last = mem_dq_in;
          if (cur.wr && (!mem_dq_oe || mem_dq_out !== cur.wdata)) m_baddq++;
          if (!cur.wr && mem_dq_oe) m_baddq++;
        end
      end else if (in_acc) begin
        in_acc = 0;
        chk(m_pre == cur.pre, "R5/R6/R7 setup+hold cycles", m_pre, cur.pre);
        chk(m_adv == cur.adv, "R8 adv low cycles", m_adv, cur.adv);
        chk(m_dat == cur.dat, "R3/R4 data cycles", m_dat, cur.dat);
        chk(cur.wr ? (m_we == cur.dat && m_oe == 0) : (m_oe == cur.dat && m_we == 0),
            "R3 strobe kind", cur.wr ? m_we : m_oe, cur.dat);
        chk(m_badaddr == 0, "R9 address held", m_badaddr, 0);
        chk(m_baddq == 0, "R8/R13 data line contents", m_baddq, 0);
        chk(ack == 1'b1, "R11 ack after last data cycle", ack, 1);
        chk(mem_oe_n && mem_we_n && mem_adv_n, "R11 strobes idle at ack", 0, 0);
        if (!cur.wr) chk(rd_data === m_last, "R10 read data", rd_data, m_last);
        ack_drop = 1;
      end else if (ack && !ack_drop) begin
        chk(1'b0, "R11 spurious ack", 1, 0);
      end
    end
  end

  // ---- driver ----
  task automatic write_cfg(input logic [15:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    cur_cfg = v;
  endtask

  task automatic push_exp(input bit wr, input bit mux, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    int s, h, dl;
    s  = cur_cfg[3:0];
    if (mux && s == 0) s = 1;
    h  = (cur_cfg[7:4] == 0) ? 1 : int'(cur_cfg[7:4]);
    dl = (cur_cfg[15:8] == 0) ? 1 : int'(cur_cfg[15:8]);
    e.pre = mux ? s + h : s;
    e.adv = mux ? s : 0;
    e.dat = dl; e.wr = wr; e.mux = mux; e.addr = a; e.wdata = d;
    q.push_back(e);
  endtask

  task automatic start_acc(input bit wr, input bit mux, input logic [AW-1:0] a, input logic [DW-1:0] d);
    push_exp(wr, mux, a, d);
    req = 1; req_write = wr; req_mux = mux; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    chk(mem_cs_n == 1'b0, "R9 select one cycle after req", mem_cs_n, 0);
  endtask

  task automatic wait_done();
    while (!ack) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [15:0] c, input bit wr, input bit mux,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    write_cfg(c);
    start_acc(wr, mux, a, d);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n && !ack && !mem_dq_oe,
        "R11 pins idle in reset", 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 1'b1 && ack == 1'b0, "R9 idle after reset", mem_cs_n, 1);

    // R2: reset word 0xFFFF, non-multiplexed read
    start_acc(0, 0, 16'h1234, 16'h0);
    wait_done();
    // R5: setup 0 in non-mux mode, data 3
    run(16'h0300, 0, 0, 16'h0F0F, 16'h0);
    // R4: data 0 -> 1 cycle, write, no setup
    run(16'h0000, 1, 0, 16'h00A5, 16'hBEEF);
    // R6/R7: mux read, setup 0 -> 1, hold 0 -> 1
    run(16'h0000, 0, 1, 16'h5A5A, 16'h0);
    // R1/R7/R13: mux write, data 10 hold 5 setup 2
    run(16'h0A52, 1, 1, 16'hC3C3, 16'h1111);
    // R7: hold field ignored in non-mux write
    run(16'h04F7, 1, 0, 16'h7777, 16'h2222);
    // R6: mux read, setup 0 -> 1, hold 15, data 1
    run(16'h01F0, 0, 1, 16'h8001, 16'h0);
    // R3: max data length under non-mux write
    run(16'hFF01, 1, 0, 16'h4444, 16'h9999);

    // R12: mid-access timing write and R11 ignored req
    write_cfg(16'h0622);
    start_acc(0, 0, 16'h3333, 16'h0);
    write_cfg(16'h0111);
    req = 1; req_write = 1; req_addr = 16'hDEAD; req_wdata = 16'hFFFF;
    @(negedge clk);
    req = 0;
    wait_done();
    repeat (4) @(negedge clk);
    chk(mem_cs_n == 1'b1 && q.size() == 0, "R11 busy req ignored", q.size(), 0);
    start_acc(0, 0, 16'h3334, 16'h0);
    wait_done();
    chk(q.size() == 0, "R12 all accesses seen", q.size(), 0);

    finished = 1;
  end

  initial begin
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule